// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Match Unit

This block decides, every cycle, whether any of a bank of hardware breakpoint comparators or hardware watchpoint comparators should fire. Each breakpoint keeps a control word and a value word. It is a candidate when it is armed and its value equals the current program counter. Each watchpoint keeps a control word only. Its address compare is done elsewhere and reaches the block as one hit bit per comparator, together with a flag that marks the access as unprivileged. A candidate then passes through two filters taken from its control word: a security-state filter and a privilege filter that depends on the current exception level.

A comparator can also be linked to a context comparator. Such a comparator is a breakpoint whose type field selects a context-ID match. The link only holds when the linked index lies in the legal window at the top of the breakpoint bank, and when that context comparator matches the current context ID at exception level 1 or below. The per-comparator results and their OR are combinational outputs. Exception generation is left to the consumer. A global monitor enable and a debug-allowed qualifier gate everything.

Comparator words are written through a small select/index/data port with a write enable. A write takes effect at the next clock edge.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every comparator is disarmed, so `bp_vec`, `wp_vec`, `bp_hit` and `wp_hit` are all 0 whatever `pc` and `wp_hit_in` are.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_sel` picks the target: 0 is a breakpoint control word, 1 is a breakpoint value word, 2 is a watchpoint control word, and 3 is ignored. `cfg_idx` names the comparator. The new word governs matching from that edge on. A write whose index is at or above the bank size changes nothing.
- R3: No comparator matches unless `debug_mon_en` and `debug_allow` are both 1.
- R4: A breakpoint is a candidate only when bit 0 of its control word is 1 and its value word equals `pc`.
- R5: A watchpoint is a candidate only when bit 0 of its control word is 1 and its bit in `wp_hit_in` is 1.
- R6: Control bits [15:14] filter on security state: 0 passes in either state, 1 or 3 pass only when `in_secure` is 0, and 2 passes only when `in_secure` is 1.
- R7: At exception level 2 or 3 a match needs control bit 13. At level 1 it needs control bit 1, and at level 0 it needs control bit 2.
- R8: For a watchpoint, `wp_unpriv` = 1 applies the privilege filter of level 0 whatever `cur_el` is.
- R9: When control bit 20 is 1, a match also needs a link. Bits [19:16] name the linked breakpoint, which must lie in [NUM_BP-NUM_CTX, NUM_BP-1]. That breakpoint must have bit 0 set and type bits [23:20] equal to 3. `cur_el` must be at most 1, and the linked value bits [31:0] must equal `ctx_id`.
- R10: `bp_vec`/`wp_vec` give one result per comparator, and `bp_hit`/`wp_hit` are their ORs, all combinational from the current inputs and stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Comparator word write enable |
| cfg_sel | input | 2 | Target: 0 bp control, 1 bp value, 2 wp control, 3 none |
| cfg_idx | input | IDX_W | Comparator index |
| cfg_wdata | input | VAL_W | Write data |
| debug_mon_en | input | 1 | Global monitor-mode debug enable |
| debug_allow | input | 1 | Debug exceptions currently permitted |
| cur_el | input | 2 | Current exception level |
| in_secure | input | 1 | Current security state is secure |
| ctx_id | input | 32 | Current context ID |
| pc | input | VAL_W | Current program counter |
| wp_hit_in | input | NUM_WP | External address-hit bit per watchpoint |
| wp_unpriv | input | 1 | Watchpoint access is unprivileged |
| bp_vec | output | NUM_BP | Per-breakpoint match |
| wp_vec | output | NUM_WP | Per-watchpoint match |
| bp_hit | output | 1 | Any breakpoint matches |
| wp_hit | output | 1 | Any watchpoint matches |

## Verification
Some properties are checked on every cycle. The global gate blocks all results. A watchpoint never reports without its external hit bit. Every reported breakpoint is armed and equal to the program counter. A reported comparator obeys the secure-only setting, the level-0 privilege bit and the unprivileged-access rule, and a linked match occurs only at level 1 or below. A disarming write silences its comparator on the next cycle. The directed scenarios are needed for the positive cases: that each filter setting does pass, the exact bounds of the link window, type codes other than context-ID, context mismatch, and that writes to the ignored select or an out-of-range index leave matching unchanged.

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 4,
  parameter int NUM_CTX = 2,
  parameter int VAL_W   = 32,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [VAL_W-1:0]  cfg_wdata,
  input  logic              debug_mon_en,
  input  logic              debug_allow,
  input  logic [1:0]        cur_el,
  input  logic              in_secure,
  input  logic [31:0]       ctx_id,
  input  logic [VAL_W-1:0]  pc,
  input  logic [NUM_WP-1:0] wp_hit_in,
  input  logic              wp_unpriv,
  output logic [NUM_BP-1:0] bp_vec,
  output logic [NUM_WP-1:0] wp_vec,
  output logic              bp_hit,
  output logic              wp_hit
);
  localparam int BPF    = 14;
  localparam int WPF    = 11;
  localparam int CTX_LO = NUM_BP - NUM_CTX;

  // stored field layout: [0] arm, [2:1] privilege, [3] hyp, [5:4] security,
  // [9:6] link index, [10] linked, [13:10] type (breakpoints only)
  logic [NUM_BP-1:0][BPF-1:0]   bp_ctl;
  logic [NUM_BP-1:0][VAL_W-1:0] bp_val;
  logic [NUM_WP-1:0][WPF-1:0]   wp_ctl;
  logic [NUM_BP-1:0]            ctx_ok;
  logic                         gate;
  logic [1:0]                   wp_el;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_ctl <= '0;
      bp_val <= '0;
      wp_ctl <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (cfg_idx == IDX_W'(i) && cfg_sel == 2'd0)
          bp_ctl[i] <= {cfg_wdata[23:13], cfg_wdata[2:0]};
        if (cfg_idx == IDX_W'(i) && cfg_sel == 2'd1)
          bp_val[i] <= cfg_wdata;
      end
      for (int i = 0; i < NUM_WP; i++) begin
        if (cfg_idx == IDX_W'(i) && cfg_sel == 2'd2)
          wp_ctl[i] <= {cfg_wdata[20:13], cfg_wdata[2:0]};
      end
    end
  end

  function automatic logic filt_ok(input logic [5:0] f, input logic [1:0] el,
                                   input logic sec);
    logic s_ok, p_ok;
    case (f[5:4])
      2'd0:    s_ok = 1'b1;
      2'd2:    s_ok = sec;
      default: s_ok = !sec;
    endcase
    case (el)
      2'd0:    p_ok = f[2];
      2'd1:    p_ok = f[1];
      default: p_ok = f[3];
    endcase
    return s_ok && p_ok;
  endfunction

  function automatic logic link_ok(input logic linked, input logic [3:0] lbn,
                                   input logic [NUM_BP-1:0] cv);
    logic r;
    r = !linked;
    for (int k = 0; k < NUM_BP; k++)
      if (linked && lbn == 4'(k) && cv[k]) r = 1'b1;
    return r;
  endfunction

  assign gate  = debug_mon_en & debug_allow;
  assign wp_el = wp_unpriv ? 2'd0 : cur_el;

  for (genvar k = 0; k < NUM_BP; k++) begin : g_ctx
    localparam logic IN_WIN = (k >= CTX_LO);
    assign ctx_ok[k] = IN_WIN && bp_ctl[k][0] && (bp_ctl[k][13:10] == 4'd3) &&
                       (cur_el <= 2'd1) && (bp_val[k][31:0] == ctx_id);
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    assign bp_vec[i] = gate && bp_ctl[i][0] && (bp_val[i] == pc) &&
                       filt_ok(bp_ctl[i][5:0], cur_el, in_secure) &&
                       link_ok(bp_ctl[i][10], bp_ctl[i][9:6], ctx_ok);
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    assign wp_vec[i] = gate && wp_ctl[i][0] && wp_hit_in[i] &&
                       filt_ok(wp_ctl[i][5:0], wp_el, in_secure) &&
                       link_ok(wp_ctl[i][10], wp_ctl[i][9:6], ctx_ok);
  end

  assign bp_hit = |bp_vec;
  assign wp_hit = |wp_vec;
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk #(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int VAL_W  = 32,
  parameter int IDX_W  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [1:0]                   cfg_sel,
  input logic [IDX_W-1:0]             cfg_idx,
  input logic                         cfg_bit0,
  input logic                         debug_mon_en,
  input logic                         debug_allow,
  input logic [1:0]                   cur_el,
  input logic                         in_secure,
  input logic                         wp_unpriv,
  input logic [VAL_W-1:0]             pc,
  input logic [NUM_WP-1:0]            wp_hit_in,
  input logic [NUM_BP-1:0]            bp_vec,
  input logic [NUM_WP-1:0]            wp_vec,
  input logic                         bp_hit,
  input logic                         wp_hit,
  input logic [NUM_BP-1:0][13:0]      bp_ctl,
  input logic [NUM_BP-1:0][VAL_W-1:0] bp_val,
  input logic [NUM_WP-1:0][10:0]      wp_ctl
);
  logic fields_unused;
  assign fields_unused = ^{bp_ctl, wp_ctl};

  assert_gate_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(debug_mon_en && debug_allow) |-> (!bp_hit && !wp_hit));

  assert_wp_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_vec & ~wp_hit_in) == '0);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bpchk
    assert_disarm_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd0 && cfg_idx == IDX_W'(i) && !cfg_bit0) |=> !bp_vec[i]);
    assert_bp_armed_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bp_vec[i] |-> (bp_ctl[i][0] && bp_val[i] == pc));
    assert_secure_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_vec[i] && bp_ctl[i][5:4] == 2'd2) |-> in_secure);
    assert_el0_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_vec[i] && cur_el == 2'd0) |-> bp_ctl[i][2]);
    assert_link_el_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_vec[i] && bp_ctl[i][10]) |-> (cur_el <= 2'd1));
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wpchk
    assert_unpriv_el0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_vec[i] && wp_unpriv) |-> wp_ctl[i][2]);
  end
endmodule

bind dbg_match_unit dbg_match_unit_chk #(
  .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .VAL_W(VAL_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_idx(cfg_idx), .cfg_bit0(cfg_wdata[0]), .debug_mon_en(debug_mon_en),
  .debug_allow(debug_allow), .cur_el(cur_el), .in_secure(in_secure),
  .wp_unpriv(wp_unpriv), .pc(pc), .wp_hit_in(wp_hit_in), .bp_vec(bp_vec),
  .wp_vec(wp_vec), .bp_hit(bp_hit), .wp_hit(wp_hit), .bp_ctl(bp_ctl),
  .bp_val(bp_val), .wp_ctl(wp_ctl)
);

// File: tb/tb_dbg_match_unit.sv
module tb_dbg_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        debug_mon_en = 1'b1;
  logic        debug_allow = 1'b1;
  logic [1:0]  cur_el = 2'd1;
  logic        in_secure = 1'b0;
  logic [31:0] ctx_id = '0;
  logic [31:0] pc = '0;
  logic [3:0]  wp_hit_in = '0;
  logic        wp_unpriv = 1'b0;
  logic [3:0]  bp_vec, wp_vec;
  logic        bp_hit, wp_hit;
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  dbg_match_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .debug_mon_en(debug_mon_en),
    .debug_allow(debug_allow), .cur_el(cur_el), .in_secure(in_secure),
    .ctx_id(ctx_id), .pc(pc), .wp_hit_in(wp_hit_in), .wp_unpriv(wp_unpriv),
    .bp_vec(bp_vec), .wp_vec(wp_vec), .bp_hit(bp_hit), .wp_hit(wp_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look();
    #2;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 4'(i), 32'h0);
      wr(2'd2, 4'(i), 32'h0);
    end
    debug_mon_en = 1'b1; debug_allow = 1'b1; cur_el = 2'd1; in_secure = 1'b0;
    wp_unpriv = 1'b0; wp_hit_in = '0; ctx_id = '0; pc = '0;
  endtask

  task automatic t_reset();
    pc = 32'h0; wp_hit_in = 4'hF; look();
    chk("R1 bp_vec", {28'b0, bp_vec}, 32'h0);
    chk("R1 wp_vec", {28'b0, wp_vec}, 32'h0);
    chk("R1 hits", {30'b0, bp_hit, wp_hit}, 32'h0);
  endtask

  task automatic t_cfg();
    clear_all();
    wr(2'd1, 4'd0, 32'h100); wr(2'd0, 4'd0, 32'h2007);
    pc = 32'h100; look();
    chk("R2 write applies", {28'b0, bp_vec}, 32'h1);
    wr(2'd1, 4'd1, 32'h100); wr(2'd0, 4'd5, 32'h2007); look();
    chk("R2 out-of-range idx", {28'b0, bp_vec}, 32'h1);
    wr(2'd3, 4'd1, 32'h2007); look();
    chk("R2 select 3 ignored", {28'b0, bp_vec}, 32'h1);
    wr(2'd0, 4'd1, 32'h2007); look();
    chk("R10 two bp vec", {28'b0, bp_vec}, 32'h3);
    chk("R10 bp_hit", {31'b0, bp_hit}, 32'h1);
    wr(2'd0, 4'd0, 32'h2006); look();
    chk("R2 disarm", {28'b0, bp_vec}, 32'h2);
  endtask

  task automatic t_bp_gate();
    clear_all();
    wr(2'd1, 4'd0, 32'h1000); wr(2'd0, 4'd0, 32'h2007);
    pc = 32'h1000; look();
    chk("R4 pc equal", {28'b0, bp_vec}, 32'h1);
    pc = 32'h1004; look();
    chk("R4 pc differs", {28'b0, bp_vec}, 32'h0);
    pc = 32'h1000; debug_mon_en = 1'b0; look();
    chk("R3 monitor off", {31'b0, bp_hit}, 32'h0);
    debug_mon_en = 1'b1; debug_allow = 1'b0; look();
    chk("R3 not allowed", {31'b0, bp_hit}, 32'h0);
    debug_allow = 1'b1; look();
    chk("R3 both on", {31'b0, bp_hit}, 32'h1);
  endtask

  task automatic t_priv();
    clear_all();
    wr(2'd1, 4'd0, 32'h40); pc = 32'h40;
    wr(2'd0, 4'd0, 32'h0003);
    cur_el = 2'd1; look(); chk("R7 el1 bit1", {28'b0, bp_vec}, 32'h1);
    cur_el = 2'd0; look(); chk("R7 el0 no bit2", {28'b0, bp_vec}, 32'h0);
    cur_el = 2'd2; look(); chk("R7 el2 no hyp", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd0, 32'h0005);
    cur_el = 2'd0; look(); chk("R7 el0 bit2", {28'b0, bp_vec}, 32'h1);
    cur_el = 2'd1; look(); chk("R7 el1 no bit1", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd0, 32'h2001);
    cur_el = 2'd3; look(); chk("R7 el3 hyp", {28'b0, bp_vec}, 32'h1);
    cur_el = 2'd1; look(); chk("R7 el1 hyp only", {28'b0, bp_vec}, 32'h0);
  endtask

  task automatic t_sec();
    clear_all();
    wr(2'd1, 4'd2, 32'h80); pc = 32'h80;
    wr(2'd0, 4'd2, 32'h6007);
    in_secure = 1'b0; look(); chk("R6 ssc1 nonsecure", {28'b0, bp_vec}, 32'h4);
    in_secure = 1'b1; look(); chk("R6 ssc1 secure", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd2, 32'hA007);
    look(); chk("R6 ssc2 secure", {28'b0, bp_vec}, 32'h4);
    in_secure = 1'b0; look(); chk("R6 ssc2 nonsecure", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd2, 32'hE007);
    look(); chk("R6 ssc3 nonsecure", {28'b0, bp_vec}, 32'h4);
    in_secure = 1'b1; look(); chk("R6 ssc3 secure", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd2, 32'h2007);
    look(); chk("R6 ssc0 secure", {28'b0, bp_vec}, 32'h4);
  endtask

  task automatic t_wp();
    clear_all();
    wr(2'd2, 4'd1, 32'h0005);
    cur_el = 2'd1; wp_hit_in = 4'b0010; look();
    chk("R8 privileged at el1", {28'b0, wp_vec}, 32'h0);
    wp_unpriv = 1'b1; look();
    chk("R8 unprivileged as el0", {28'b0, wp_vec}, 32'h2);
    chk("R10 wp_hit", {31'b0, wp_hit}, 32'h1);
    wp_hit_in = 4'b0000; look();
    chk("R5 no external hit", {28'b0, wp_vec}, 32'h0);
    wr(2'd2, 4'd1, 32'h0004); wp_hit_in = 4'b0010; look();
    chk("R5 disarmed", {28'b0, wp_vec}, 32'h0);
  endtask

  task automatic t_link();
    clear_all();
    ctx_id = 32'hCAFE0001; pc = 32'h2000; cur_el = 2'd1;
    wr(2'd1, 4'd3, 32'hCAFE0001); wr(2'd0, 4'd3, 32'h00300001);
    wr(2'd1, 4'd0, 32'h2000); wr(2'd0, 4'd0, 32'h00132007);
    look(); chk("R9 link to 3", {28'b0, bp_vec}, 32'h1);
    ctx_id = 32'hCAFE0002; look(); chk("R9 ctx mismatch", {28'b0, bp_vec}, 32'h0);
    ctx_id = 32'hCAFE0001; cur_el = 2'd2; look();
    chk("R9 el2 blocks ctx", {28'b0, bp_vec}, 32'h0);
    cur_el = 2'd1;
    wr(2'd1, 4'd1, 32'hCAFE0001); wr(2'd0, 4'd1, 32'h00300001);
    wr(2'd0, 4'd0, 32'h00112007); look();
    chk("R9 below window", {28'b0, bp_vec}, 32'h0);
    wr(2'd1, 4'd2, 32'hCAFE0001); wr(2'd0, 4'd2, 32'h00300001);
    wr(2'd0, 4'd0, 32'h00122007); look();
    chk("R9 window low edge", {28'b0, bp_vec}, 32'h1);
    wr(2'd0, 4'd0, 32'h00132007); wr(2'd0, 4'd3, 32'h00500001); look();
    chk("R9 other type", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd3, 32'h00300000); look();
    chk("R9 target disarmed", {28'b0, bp_vec}, 32'h0);
    wr(2'd0, 4'd3, 32'h00300001);
    wr(2'd2, 4'd0, 32'h00132007); wp_hit_in = 4'b0001; look();
    chk("R9 wp linked", {28'b0, wp_vec}, 32'h1);
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_bp_gate();
    t_priv();
    t_sec();
    t_wp();
    t_link();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule